// File: doc/BRIEF.md
# Disk Head Stepper Phase Sequencer

This block drives the four phase lines of a disk head stepper motor. The lines are active low: a phase is energized when its line is 0. The block holds the head at the current position and moves it one half track for each step request it accepts. A direction input chooses which way the head moves. The energized pattern rotates cyclically across the four lines, so the step after phase 3 is phase 0, and a step back from phase 0 is phase 3.

Two drive modes are available. In wave drive a single line is low. In full-step drive two neighbouring lines are low together. The phases can be switched off entirely. Whenever they are switched back on, a settling lockout runs for a set time, 20 ms by default, with its length in cycles derived from the clock frequency parameter. Ready is reported only after the lockout ends. The block ignores any step request that arrives while it is not ready. A signed half-track counter follows every accepted step, and it saturates at its limits.

Top module: `head_phase_seq`

## Requirements
- R1: While rst_ni is low, and before the first clock edge that follows release, phase_n_o is 4'b1111, ready_o is 0 and pos_o is 0. Reset leaves the phase index at 0, the mode at wave and the phases off.
- R2: After a clock edge that samples enable_i low, phase_n_o is 4'b1111 and ready_o is 0.
- R3: Take the first edge that samples enable_i high after it was low. ready_o stays 0 after each of the next SETTLE_CYC-1 edges, counting that first edge as edge 1, and becomes 1 after edge SETTLE_CYC. SETTLE_CYC = CLK_HZ/1000*SETTLE_MS, with a minimum of 2.
- R4: Wave drive (full_step_i sampled 0) with the phases on: only bit idx of phase_n_o is 0, where bit k drives phase k.
- R5: Full-step drive (full_step_i sampled 1) with the phases on: bits idx and (idx+1) mod 4 of phase_n_o are 0 and the other two bits are 1.
- R6: An accepted step with dir_i=1 changes idx to (idx+1) mod 4 and adds 1 to pos_o. With dir_i=0 it changes idx to (idx-1) mod 4 and subtracts 1. The result is visible after the edge that samples step_i.
- R7: step_i sampled while ready_o is 0 has no effect on the phase index or on pos_o. This covers both settling and phases-off.
- R8: pos_o is a signed POS_W-bit count. A step that would move it above 2^(POS_W-1)-1 or below -2^(POS_W-1) is ignored entirely, so the phase index does not move either.
- R9: A change of full_step_i takes effect on phase_n_o after the next edge. It changes neither idx nor pos_o, and it does not drop ready_o.
- R10: Switching the phases off and on again keeps idx and pos_o, and the full R3 lockout runs again before ready_o returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Step request, sampled each edge |
| dir_i | input | 1 | Step direction, 1 = increasing index |
| full_step_i | input | 1 | 1 = two adjacent phases on, 0 = one phase on |
| enable_i | input | 1 | 1 = phases energized, 0 = all phases off |
| phase_n_o | output | 4 | Active-low phase lines, bit k = phase k |
| ready_o | output | 1 | Energized and settled; steps are accepted |
| pos_o | output | POS_W | Signed half-track position |

## Verification
The assertions assume every input is synchronous to clk_i and settled at each rising edge. They also assume the settle length is at least two cycles, so that one counter in the checker can bound how early ready may appear. The stimulus changes inputs only on the falling edge. The bench is built with a short clock frequency parameter so that each lockout lasts a few thousand cycles. Step requests arrive at every phase of the lockout, during phases-off and at both counter limits, so that the ignore rules and the saturation rule are each exercised at their edges.

// File: rtl/head_phase_pkg.sv
package head_phase_pkg;
  localparam int unsigned NPH   = 4;
  localparam int unsigned IDX_W = $clog2(NPH);

  typedef enum logic {
    DRV_WAVE = 1'b0,
    DRV_FULL = 1'b1
  } drv_mode_e;

  typedef logic [IDX_W-1:0] ph_idx_t;

  // cyclic neighbour; NPH is a power of two so the index wraps naturally
  function automatic ph_idx_t ph_step(ph_idx_t cur, logic up);
    return up ? ph_idx_t'(cur + 1'b1) : ph_idx_t'(cur - 1'b1);
  endfunction
endpackage

// File: rtl/hp_settle_timer.sv
module hp_settle_timer #(
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  output logic energized_o,
  output logic ready_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LOAD;
      en_q  <= 1'b0;
    end else begin
      en_q <= enable_i;
      if (!enable_i)          cnt_q <= LOAD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign energized_o = en_q;
  assign ready_o     = en_q && (cnt_q == '0);
endmodule

// File: rtl/hp_pos_counter.sv
module hp_pos_counter #(
  parameter int unsigned POS_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    dir_i,
  output logic                    move_o,
  output logic signed [POS_W-1:0] pos_o
);
  localparam logic signed [POS_W-1:0] PMAX = {1'b0, {(POS_W-1){1'b1}}};
  localparam logic signed [POS_W-1:0] PMIN = {1'b1, {(POS_W-1){1'b0}}};

  logic signed [POS_W-1:0] pos_q;
  logic                    at_lim;

  assign at_lim = dir_i ? (pos_q == PMAX) : (pos_q == PMIN);
  assign move_o = req_i && !at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= '0;
    else if (move_o)  pos_q <= dir_i ? pos_q + 1'b1 : pos_q - 1'b1;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/hp_phase_ring.sv
module hp_phase_ring
  import head_phase_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           adv_i,
  input  logic           dir_i,
  input  logic           full_i,
  input  logic           energized_i,
  output drv_mode_e      mode_o,
  output logic [NPH-1:0] phase_n_o
);
  ph_idx_t   idx_q;
  ph_idx_t   idx_nb;
  drv_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      mode_q <= DRV_WAVE;
    end else begin
      mode_q <= full_i ? DRV_FULL : DRV_WAVE;
      if (adv_i) idx_q <= ph_step(idx_q, dir_i);
    end
  end

  assign idx_nb = ph_step(idx_q, 1'b1);

  for (genvar k = 0; k < NPH; k++) begin : g_line
    logic on;
    assign on = (idx_q == ph_idx_t'(k)) ||
                ((mode_q == DRV_FULL) && (idx_nb == ph_idx_t'(k)));
    assign phase_n_o[k] = !(energized_i && on);
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/head_phase_seq.sv
module head_phase_seq
  import head_phase_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 250_000_000,
  parameter int unsigned SETTLE_MS = 20,
  parameter int unsigned POS_W     = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    step_i,
  input  logic                    dir_i,
  input  logic                    full_step_i,
  input  logic                    enable_i,
  output logic [3:0]              phase_n_o,
  output logic                    ready_o,
  output logic signed [POS_W-1:0] pos_o
);
  localparam int unsigned RAW_CYC    = (CLK_HZ / 1000) * SETTLE_MS;
  localparam int unsigned SETTLE_CYC = (RAW_CYC < 2) ? 2 : RAW_CYC;

  logic      energized;
  logic      rdy;
  logic      move;
  drv_mode_e mode;

  hp_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .energized_o (energized),
    .ready_o     (rdy)
  );

  hp_pos_counter #(.POS_W(POS_W)) u_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (step_i && rdy),
    .dir_i  (dir_i),
    .move_o (move),
    .pos_o  (pos_o)
  );

  hp_phase_ring u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (move),
    .dir_i       (dir_i),
    .full_i      (full_step_i),
    .energized_i (energized),
    .mode_o      (mode),
    .phase_n_o   (phase_n_o)
  );

  assign ready_o = rdy;
endmodule

// File: rtl/hp_seq_checker.sv
module hp_seq_checker #(
  parameter int unsigned SETTLE_CYC = 2,
  parameter int unsigned POS_W      = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    energized_i,
  input logic                    full_i,
  input logic                    ready_i,
  input logic [3:0]              phase_n_i,
  input logic signed [POS_W-1:0] pos_i
);
  localparam int unsigned ON_W = $clog2(SETTLE_CYC + 1);
  localparam logic [ON_W-1:0] ON_MAX = ON_W'(SETTLE_CYC);
  localparam logic [ON_W-1:0] ON_MIN = ON_W'(SETTLE_CYC - 1);

  logic [ON_W-1:0] on_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 on_cnt <= '0;
    else if (!energized_i)       on_cnt <= '0;
    else if (on_cnt != ON_MAX)   on_cnt <= on_cnt + 1'b1;
  end

  a_r2_off_all_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !energized_i |-> phase_n_i == 4'b1111);

  a_r3_ready_needs_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> energized_i);

  a_r3_settle_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> on_cnt >= ON_MIN);

  a_r4_wave_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (energized_i && !full_i) |-> $countones(~phase_n_i) == 1);

  a_r5_full_adjacent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (energized_i && full_i) |->
      (phase_n_i == 4'b1100 || phase_n_i == 4'b1001 ||
       phase_n_i == 4'b0011 || phase_n_i == 4'b0110));

  a_r6_unit_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> (pos_i == $past(pos_i)) ||
                (pos_i == $past(pos_i) + POS_W'(1)) ||
                (pos_i == $past(pos_i) - POS_W'(1)));

  a_r7_hold_unready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> $stable(pos_i));
endmodule

bind head_phase_seq hp_seq_checker #(
  .SETTLE_CYC (SETTLE_CYC),
  .POS_W      (POS_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .energized_i (energized),
  .full_i      (mode == head_phase_pkg::DRV_FULL),
  .ready_i     (rdy),
  .phase_n_i   (phase_n_o),
  .pos_i       (pos_o)
);

// File: tb/sim_head_phase_seq.sv
`timescale 1ns/1ps
module sim_head_phase_seq;
  localparam int unsigned CLK_HZ = 100_000;
  localparam int unsigned SMS    = 20;
  localparam int unsigned POS_W  = 5;
  localparam int          SET    = (CLK_HZ / 1000) * SMS;
  localparam int          PMAX   = (1 << (POS_W - 1)) - 1;
  localparam int          PMIN   = -(1 << (POS_W - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0, dir = 1'b0, full = 1'b0, en = 1'b0;
  logic [3:0] ph_n;
  logic rdy;
  logic signed [POS_W-1:0] pos;

  always #2 clk = ~clk;

  head_phase_seq #(.CLK_HZ(CLK_HZ), .SETTLE_MS(SMS), .POS_W(POS_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .dir_i(dir),
    .full_step_i(full), .enable_i(en),
    .phase_n_o(ph_n), .ready_o(rdy), .pos_o(pos)
  );

  typedef struct {
    logic [3:0] ph;
    logic       rd;
    int         ps;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state
  bit m_en = 0, m_full = 0;
  int m_cnt = SET, m_idx = 0, m_pos = 0;

  function automatic logic [3:0] pat(int idx, bit fl, bit e);
    logic [3:0] on;
    on = 4'b0001 << idx;
    if (fl) on = on | (4'b0001 << ((idx + 1) % 4));
    return e ? ~on : 4'b1111;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(bit s, bit d, bit f, bit e, string tag);
    bit rnow, acc;
    exp_t x;
    @(negedge clk);
    step = s; dir = d; full = f; en = e;
    rnow = m_en && (m_cnt == 0);
    acc  = s && rnow && !(d ? (m_pos == PMAX) : (m_pos == PMIN));
    m_en = e;
    m_cnt = e ? ((m_cnt > 0) ? m_cnt - 1 : 0) : SET;
    m_full = f;
    if (acc) begin
      m_idx = d ? (m_idx + 1) % 4 : (m_idx + 3) % 4;
      m_pos = d ? m_pos + 1 : m_pos - 1;
    end
    x.ph = pat(m_idx, m_full, m_en);
    x.rd = m_en && (m_cnt == 0);
    x.ps = m_pos;
    x.tag = tag;
    q.push_back(x);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "phase_n", int'(ph_n), int'(e.ph));
        chk(e.tag, "ready", int'(rdy), int'(e.rd));
        chk(e.tag, "pos", int'(pos), e.ps);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    #1;
    chk("R1", "phase_n", int'(ph_n), 15);
    chk("R1", "ready", int'(rdy), 0);
    chk("R1", "pos", int'(pos), 0);
    #9;
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1", "phase_n", int'(ph_n), 15);
    chk("R1", "ready", int'(rdy), 0);

    // R7: steps while off are ignored
    for (int i = 0; i < 3; i++) tick(1, 1, 0, 0, "R7");
    // R3: settle lockout, with steps during it (R7)
    for (int i = 0; i < SET + 2; i++) tick(i % 97 == 5, 1, 0, 1, (i < SET) ? "R3" : "R3");
    // R4, R6: wave drive steps up with wrap, then down with wrap
    for (int i = 0; i < 6; i++) tick(1, 1, 0, 1, "R6");
    tick(0, 1, 0, 1, "R4");
    for (int i = 0; i < 8; i++) tick(1, 0, 0, 1, "R6");
    // R9: switch to full step, no movement
    tick(0, 0, 1, 1, "R9");
    tick(0, 0, 1, 1, "R9");
    // R5: full step both ways
    for (int i = 0; i < 5; i++) tick(1, 1, 1, 1, "R5");
    for (int i = 0; i < 3; i++) tick(1, 0, 1, 1, "R5");
    tick(0, 0, 0, 1, "R9");
    // R8: saturate high then low
    for (int i = 0; i < 20; i++) tick(1, 1, 0, 1, "R8");
    for (int i = 0; i < 40; i++) tick(1, 0, 0, 1, "R8");
    for (int i = 0; i < 3; i++) tick(1, 1, 1, 1, "R8");
    // R2, R10: off, steps ignored, back on, full settle again
    for (int i = 0; i < 4; i++) tick(1, 1, 1, 0, "R2");
    for (int i = 0; i < SET + 2; i++) tick(i == SET - 2, 0, 1, 1, "R10");
    for (int i = 0; i < 3; i++) tick(1, 0, 1, 1, "R6");
    // short off glitch restarts lockout (R10)
    tick(0, 0, 0, 0, "R2");
    for (int i = 0; i < SET + 1; i++) tick(0, 0, 0, 1, "R10");

    wait (q.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule